// File: doc/BRIEF.md
# Command-Framed Serial Slave Controller

This block is a serial slave that samples its data line on the system clock while an active-low select is held. Each frame opens with one control bit that chooses a write path or a read path. A 10-bit command word follows, most significant bit first. The block presents that word in parallel with a one-cycle valid strobe. The two top bits of the word are a command code that a memory-side neighbour decodes.

For a read-data fetch, the block waits until the memory side raises its byte-valid flag. It then loads the offered byte and shifts it out on the return line over eight cycles, most significant bit first. An internal flag records whether a read address has been delivered. While that flag is set, the next read-path frame is handled as a data fetch. While it is clear, a read-path frame is handled as a read address.

Top module: `spi_cmd_slave`

## Requirements
- R1: While reset (asynchronous, active low) is asserted, rx_valid is 0, rx_data is 0 and miso is 0, and the read-address flag is clear.
- R2: The first rising clock edge with ss_n low opens a frame. The following edge samples the control bit on mosi: 0 takes the write path, 1 takes the read path.
- R3: After the control bit, the next 10 mosi bits are shifted in MSB first. On the edge that samples the tenth bit, rx_data takes the word and rx_valid is 1 for exactly one cycle. rx_data then holds until the next completed word.
- R4: Raising ss_n before the tenth bit discards the partial word: no rx_valid pulse, rx_data unchanged, and the next frame starts from its control bit.
- R5: A completed word with code rx_data[9:8]=2'b10 sets the read-address flag, and code 2'b11 clears it. A read-path frame taken while the flag is clear is a read-address frame and never shifts data out.
- R6: In a read-path frame taken while the flag is set, the first edge after the word is complete at which tx_valid is 1 loads tx_data. miso then shows tx_data[7] down to tx_data[0] on the eight cycles after that edge. tx_valid held longer does not reload.
- R7: tx_valid is ignored in write frames, in read-address frames, and in a read-data frame before its word is complete.
- R8: miso is 0 whenever no byte is being shifted. ss_n going high stops a shift-out, and miso is 0 after that edge.
- R9: The low 8 bits of a read-data word are dummy bits and have no effect on the bits shifted out on miso.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| tx_valid | input | 1 | Memory side: byte ready to send |
| tx_data | input | 8 | Memory side: byte to send |
| miso | output | 1 | Serial data to the master |
| rx_valid | output | 1 | One-cycle strobe for a completed word |
| rx_data | output | 10 | Last completed command word |

## Verification
Two pairs of events can fall in the same cycle. The first is the capture of the final command bit of a read-data word and the arrival of tx_valid. The bench raises tx_valid during the cycle of the last bit. It expects miso to stay low across that edge and the byte to start one edge later, with no bit lost. The second is a deselect during a shift-out. The bench raises ss_n in the middle of a byte and expects miso to go low on that same edge. A reference model in the bench predicts every output on every clock, and the bench compares the design against it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_WRITE   = 3'd2,
        ST_RD_ADDR = 3'd3,
        ST_RD_DATA = 3'd4
    } ctl_state_e;

    localparam logic [1:0] CODE_WR_ADDR = 2'b00;
    localparam logic [1:0] CODE_WR_DATA = 2'b01;
    localparam logic [1:0] CODE_RD_ADDR = 2'b10;
    localparam logic [1:0] CODE_RD_DATA = 2'b11;

endpackage

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ss_n,
    input  logic       mosi,
    input  logic       word_vld,
    input  logic [1:0] word_code,
    output ctl_state_e state_o
);

    typedef struct packed {
        ctl_state_e st;
        logic       rd_seen;
    } fsm_regs_t;

    fsm_regs_t q, d;

    always_comb begin
        d = q;
        if (ss_n) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE:  d.st = ST_CHECK;
                ST_CHECK: begin
                    if (!mosi)          d.st = ST_WRITE;
                    else if (q.rd_seen) d.st = ST_RD_DATA;
                    else                d.st = ST_RD_ADDR;
                end
                ST_WRITE, ST_RD_ADDR, ST_RD_DATA: d.st = q.st;
                default:  d.st = ST_IDLE;
            endcase
        end
        if (word_vld && word_code == CODE_RD_ADDR) d.rd_seen = 1'b1;
        if (word_vld && word_code == CODE_RD_DATA) d.rd_seen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.rd_seen <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;

    // R2: control step always leaves for one of the three frame paths
    a_r2_check_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CHECK && !ss_n) |=> (q.st inside {ST_WRITE, ST_RD_ADDR, ST_RD_DATA}));

    // R5: a completed read-address word arms the flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_code == CODE_RD_ADDR) |=> q.rd_seen);

    // R5: a completed read-data word disarms the flag
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_code == CODE_RD_DATA) |=> !q.rd_seen);

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mosi,
    output logic [CMD_W-1:0] word_o,
    output logic             vld_o,
    output logic             full_o
);

    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    typedef struct packed {
        logic [CMD_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] word;
        logic             vld;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt != CNT_FULL) begin
            d.sh  = {q.sh[CMD_W-2:0], mosi};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_LAST) begin
                d.word = {q.sh[CMD_W-2:0], mosi};
                d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh   <= '0;
            q.cnt  <= '0;
            q.word <= '0;
            q.vld  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign word_o = q.word;
    assign vld_o  = q.vld;
    assign full_o = (q.cnt == CNT_FULL);

    // R3: the valid strobe lasts a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);

    // R4: leaving the frame drops any partial count
    a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.cnt == '0));

endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              miso_o
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LEFT_INIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic              busy;
        logic              sent;
        logic              miso;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        if (!arm) begin
            d.busy = 1'b0;
            d.sent = 1'b0;
            d.miso = 1'b0;
            d.left = '0;
        end else if (q.busy) begin
            if (q.left != '0) begin
                d.miso = q.sh[BYTE_W-1];
                d.sh   = q.sh << 1;
                d.left = q.left - 1'b1;
            end else begin
                d.miso = 1'b0;
                d.busy = 1'b0;
                d.sent = 1'b1;
            end
        end else if (!q.sent && tx_valid) begin
            d.miso = tx_data[BYTE_W-1];
            d.sh   = {tx_data[BYTE_W-2:0], 1'b0};
            d.left = LEFT_INIT;
            d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh   <= '0;
            q.left <= '0;
            q.busy <= 1'b0;
            q.sent <= 1'b0;
            q.miso <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign miso_o = q.miso;

    // R6: a shift-out only begins after the memory side offered a byte
    a_r6_load_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(tx_valid));

    // R6: a finished byte is not reloaded while the frame stays armed
    a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sent && arm) |=> !q.busy);

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int CMD_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              mosi,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              miso,
    output logic              rx_valid,
    output logic [CMD_W-1:0]  rx_data
);

    ctl_state_e state;
    logic       collect_en;
    logic       word_full;
    logic       tx_arm;

    assign collect_en = !ss_n && (state inside {ST_WRITE, ST_RD_ADDR, ST_RD_DATA});
    assign tx_arm     = !ss_n && (state == ST_RD_DATA) && word_full;

    spi_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_n      (ss_n),
        .mosi      (mosi),
        .word_vld  (rx_valid),
        .word_code (rx_data[CMD_W-1 -: 2]),
        .state_o   (state)
    );

    spi_cmd_rx #(.CMD_W(CMD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (collect_en),
        .mosi   (mosi),
        .word_o (rx_data),
        .vld_o  (rx_valid),
        .full_o (word_full)
    );

    spi_cmd_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (tx_arm),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .miso_o   (miso)
    );

    // R8: deselect silences the return line on the next edge
    a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |=> !miso);

    // R7: write frames never drive data out
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> !miso);

    // R3: a word strobe only appears inside a data-collecting frame
    a_r3_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state inside {ST_WRITE, ST_RD_ADDR, ST_RD_DATA}));

endmodule

// File: tb/spi_cmd_slave_tb_top.sv
module spi_cmd_slave_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       miso;
    logic       rx_valid;
    logic [9:0] rx_data;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    logic       e_rxv = 1'b0;
    logic [9:0] e_rxd = 10'h000;
    logic       e_miso = 1'b0;
    bit         m_seen = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_n     (ss_n),
        .mosi     (mosi),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .miso     (miso),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    task automatic compare(input string req);
        n_vec++;
        if (rx_valid !== e_rxv) begin
            n_bad++;
            $display("FAIL %s rx_valid actual=%b expected=%b t=%0t", req, rx_valid, e_rxv, $time);
        end
        if (rx_data !== e_rxd) begin
            n_bad++;
            $display("FAIL %s rx_data actual=%h expected=%h t=%0t", req, rx_data, e_rxd, $time);
        end
        if (miso !== e_miso) begin
            n_bad++;
            $display("FAIL %s miso actual=%b expected=%b t=%0t", req, miso, e_miso, $time);
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        #1;
        compare(req);
    endtask

    // ctrl: control bit; w: command word; send: offer a byte;
    // gap: idle cycles before tx_valid; early: raise tx_valid with the last bit;
    // cut: deselect after this many shifted bits (0 = full byte)
    task automatic frame(input bit ctrl, input logic [9:0] w, input bit send,
                         input logic [7:0] b, input int gap, input bit early,
                         input int cut, input string req);
        bit rd;
        bit stop;
        rd   = ctrl && m_seen;
        stop = 1'b0;
        ss_n = 1'b0; mosi = 1'b0; tx_valid = 1'b0;
        e_rxv = 1'b0; e_miso = 1'b0;
        tick({req, "/R2 open"});
        mosi = ctrl;
        tick({req, "/R2 ctrl"});
        for (int i = 9; i >= 0; i--) begin
            mosi = w[i];
            if (i == 0) begin
                e_rxv = 1'b1;
                e_rxd = w;
                if (send && early) begin
                    tx_valid = 1'b1;
                    tx_data  = b;
                end
            end
            tick({req, "/R3 word"});
        end
        e_rxv = 1'b0;
        mosi  = 1'b1;
        if (w[9]) m_seen = ~w[8];
        if (send) begin
            if (!early) begin
                for (int g = 0; g < gap; g++) begin
                    tx_valid = 1'b0;
                    tick({req, "/R7 wait"});
                end
            end
            for (int j = 0; j < 9; j++) begin
                if (!stop) begin
                    tx_valid = (j < 8) || !early;
                    tx_data  = b;
                    if (cut != 0 && j == cut) begin
                        ss_n   = 1'b1;
                        e_miso = 1'b0;
                        stop   = 1'b1;
                        tick({req, "/R8 cut"});
                    end else begin
                        e_miso = (rd && j < 8) ? b[7-j] : 1'b0;
                        tick({req, "/R6 shift"});
                    end
                end
            end
            tx_valid = 1'b0;
            e_miso   = 1'b0;
        end
        ss_n = 1'b1; mosi = 1'b0; tx_valid = 1'b0;
        tick({req, "/R8 close"});
        tick({req, "/R8 idle"});
    endtask

    task automatic abort_frame(input bit ctrl, input int nbits, input string req);
        ss_n = 1'b0; mosi = 1'b0; e_rxv = 1'b0; e_miso = 1'b0;
        tick(req);
        mosi = ctrl;
        tick(req);
        for (int i = 0; i < nbits; i++) begin
            mosi = 1'b1;
            tick(req);
        end
        ss_n = 1'b1; mosi = 1'b0;
        tick(req);
        tick(req);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #3;
        compare("R1 async reset");
        #19;
        compare("R1 reset held");
        rst_n = 1'b1;

        // write address then write data; tx_valid offered must be ignored
        frame(1'b0, {2'b00, 8'h3C}, 1'b1, 8'hA5, 0, 1'b0, 0, "R7 write addr");
        frame(1'b0, {2'b01, 8'h5A}, 1'b0, 8'h00, 0, 1'b0, 0, "R3 write data");
        // read address: flag set, tx_valid ignored
        frame(1'b1, {2'b10, 8'h3C}, 1'b1, 8'hFF, 0, 1'b0, 0, "R7 read addr");
        // read data with a two-cycle memory delay
        frame(1'b1, {2'b11, 8'h00}, 1'b1, 8'hA5, 2, 1'b0, 0, "R6 read data");
        // flag now clear: a read frame is a read address, no shift-out
        frame(1'b1, {2'b11, 8'hFF}, 1'b1, 8'h5A, 0, 1'b0, 0, "R5 flag clear");
        // re-arm, then tx_valid coincides with the last command bit
        frame(1'b1, {2'b10, 8'h01}, 1'b0, 8'h00, 0, 1'b0, 0, "R5 rearm");
        frame(1'b1, {2'b11, 8'hC3}, 1'b1, 8'h96, 0, 1'b1, 0, "R6 early valid");
        // partial words are dropped
        abort_frame(1'b0, 4, "R4 short write");
        abort_frame(1'b1, 9, "R4 short read");
        frame(1'b0, {2'b01, 8'h81}, 1'b0, 8'h00, 0, 1'b0, 0, "R4 recover");
        // dummy bits differ but the shifted byte follows tx_data only
        frame(1'b1, {2'b10, 8'h22}, 1'b0, 8'h00, 0, 1'b0, 0, "R9 addr");
        frame(1'b1, {2'b11, 8'hFF}, 1'b1, 8'h0F, 1, 1'b0, 0, "R9 dummy ones");
        frame(1'b1, {2'b10, 8'h22}, 1'b0, 8'h00, 0, 1'b0, 0, "R9 addr2");
        frame(1'b1, {2'b11, 8'h6B}, 1'b1, 8'h0F, 0, 1'b0, 0, "R9 dummy mix");
        // deselect in the middle of a shift-out
        frame(1'b1, {2'b10, 8'h44}, 1'b0, 8'h00, 0, 1'b0, 0, "R8 addr");
        frame(1'b1, {2'b11, 8'h00}, 1'b1, 8'hFF, 0, 1'b0, 3, "R8 cut shift");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule